// File: doc/BRIEF.md
# Single-Precision Float to Fixed-Point Converter

This block turns a 32-bit IEEE-754 single-precision operand into a fixed-point integer. The caller picks the number of fractional bits (0 to 31), whether the result is signed or unsigned, and whether it is 32 bits or 16 bits wide. Conversion always rounds toward zero. Values outside the chosen range saturate to the nearest limit. A flush control makes subnormal operands count as zero. Alongside each result the block reports three flags: invalid operation, inexact result, and flushed subnormal input.

The datapath is a two-stage pipeline with a valid strobe on each side. A new operand may be presented on every cycle. The block has no ready signal and applies no back-pressure: a result appears exactly two cycles after its operand, and the consumer must take it in that cycle. A 16-bit result sits in the low half of the output word. It is sign-extended in signed mode and zero-extended in unsigned mode.

Top module: `fp_to_fixed_conv`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `out_result` and all three flags are 0 until the first operand emerges.
- R2: An in-range operand gives x·2^F truncated toward zero, where F is `in_frac_bits`, as a two's-complement word (signed) or a plain binary word (unsigned).
- R3: `out_inexact` is 1 exactly when truncation discards a nonzero fraction and the result is neither saturated nor from a NaN.
- R4: A subnormal operand (exponent field 0, fraction field nonzero) with `in_flush`=1 gives result 0, `out_denorm`=1 and `out_inexact`=0. With `in_flush`=0 it gives result 0, `out_inexact`=1 and `out_denorm`=0.
- R5: A NaN operand (exponent field all ones, fraction field nonzero) gives result 0, `out_invalid`=1 and `out_inexact`=0.
- R6: In signed mode, a truncated value below −2^(W−1) gives −2^(W−1), and one above 2^(W−1)−1 gives 2^(W−1)−1, where W is 32 or 16. Both cases set `out_invalid` and clear `out_inexact`. Infinities saturate by their sign.
- R7: In unsigned mode, a truncated value that is negative and nonzero gives 0, and one above 2^W−1 gives 2^W−1. Both cases set `out_invalid` and clear `out_inexact`. A negative value that truncates to zero gives 0 with only the inexact rule applied.
- R8: `in_half`=1 selects W=16. The 16-bit result is sign-extended (signed mode) or zero-extended (unsigned mode) into `out_result`.
- R9: `out_valid` rises exactly two cycles after each `in_valid` cycle. Back-to-back operands are accepted every cycle and come out in order.
- R10: In any cycle with `out_valid`=0, `out_result` and all flags read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and controls are present this cycle |
| in_value | input | 32 | Single-precision operand |
| in_signed | input | 1 | 1 for a signed result, 0 for unsigned |
| in_half | input | 1 | 1 for a 16-bit result range |
| in_frac_bits | input | 5 | Number of fractional bits F |
| in_flush | input | 1 | Treat subnormal operands as zero |
| out_valid | output | 1 | Result and flags are valid |
| out_result | output | 32 | Fixed-point result |
| out_invalid | output | 1 | Saturation or NaN occurred |
| out_inexact | output | 1 | Truncation discarded bits |
| out_denorm | output | 1 | Subnormal operand was flushed |

## Verification
Every result and every flag is due at the second rising edge after its operand is presented. The bench drives inputs on falling edges and tags each expectation with its launch cycle. It compares at the falling edge two cycles later, so latency and value are checked together. In cycles with no expectation due, it checks that the outputs read zero.

// File: rtl/fxc_pkg.sv
package fxc_pkg;
  localparam int FP_W     = 32;
  localparam int EXP_W    = 8;
  localparam int MAN_W    = 23;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int OUT_W    = 32;
  localparam int HALF_W   = 16;
  localparam int FRAC_W   = $clog2(OUT_W);
  localparam int SIG_W    = MAN_W + 1;

  typedef struct packed {
    logic             neg;
    logic [OUT_W-1:0] mag;
    logic             huge;
    logic             lost;
    logic             nan;
    logic             denorm;
    logic             is_signed;
    logic             half;
  } fxc_mid_t;
endpackage

// File: rtl/fxc_decode.sv
module fxc_decode
  import fxc_pkg::*;
(
  input  logic [FP_W-1:0]   value,
  input  logic              is_signed,
  input  logic              half,
  input  logic [FRAC_W-1:0] frac,
  input  logic              flush,
  output fxc_mid_t          mid
);
  logic [EXP_W-1:0] expf;
  logic [MAN_W-1:0] manf;
  logic [SIG_W-1:0] sig;
  int               e_i;
  logic [FRAC_W-1:0] sh;
  logic [OUT_W-1:0] wide_sig;
  logic [OUT_W-1:0] drop_mask;

  assign expf     = value[FP_W-2 -: EXP_W];
  assign manf     = value[MAN_W-1:0];
  assign sig      = {1'b1, manf};
  assign wide_sig = OUT_W'(sig);

  always_comb begin
    mid           = '0;
    mid.neg       = value[FP_W-1];
    mid.is_signed = is_signed;
    mid.half      = half;
    e_i           = int'(expf) + int'(frac) - BIAS;
    sh            = '0;
    drop_mask     = '0;
    if (expf == {EXP_W{1'b1}}) begin
      if (manf != '0) mid.nan  = 1'b1;
      else            mid.huge = 1'b1;
    end else if (expf == '0) begin
      mid.lost   = (manf != '0) && !flush;
      mid.denorm = (manf != '0) && flush;
    end else if (e_i >= OUT_W) begin
      mid.huge = 1'b1;
    end else if (e_i >= MAN_W) begin
      sh      = FRAC_W'(e_i - MAN_W);
      mid.mag = wide_sig << sh;
    end else if (e_i >= 0) begin
      sh        = FRAC_W'(MAN_W - e_i);
      drop_mask = (OUT_W'(1) << sh) - OUT_W'(1);
      mid.mag   = wide_sig >> sh;
      mid.lost  = (wide_sig & drop_mask) != '0;
    end else begin
      mid.lost = 1'b1;
    end
  end
endmodule

// File: rtl/fxc_clamp.sv
module fxc_clamp
  import fxc_pkg::*;
(
  input  fxc_mid_t         mid,
  output logic [OUT_W-1:0] result,
  output logic             invalid,
  output logic             inexact
);
  localparam logic [OUT_W-1:0] S_MAX_F = OUT_W'((64'd1 << (OUT_W - 1)) - 1);
  localparam logic [OUT_W-1:0] S_MAX_H = OUT_W'((64'd1 << (HALF_W - 1)) - 1);
  localparam logic [OUT_W-1:0] U_MAX_F = OUT_W'((64'd1 << OUT_W) - 1);
  localparam logic [OUT_W-1:0] U_MAX_H = OUT_W'((64'd1 << HALF_W) - 1);

  logic [OUT_W-1:0] pos_lim, neg_lim, u_lim;

  assign pos_lim = mid.half ? S_MAX_H : S_MAX_F;
  assign neg_lim = pos_lim + OUT_W'(1);
  assign u_lim   = mid.half ? U_MAX_H : U_MAX_F;

  always_comb begin
    result  = '0;
    invalid = 1'b0;
    if (mid.nan) begin
      invalid = 1'b1;
    end else if (mid.is_signed) begin
      if (mid.neg) begin
        if (mid.huge || mid.mag > neg_lim) begin
          result  = ~neg_lim + OUT_W'(1);
          invalid = 1'b1;
        end else begin
          result = ~mid.mag + OUT_W'(1);
        end
      end else if (mid.huge || mid.mag > pos_lim) begin
        result  = pos_lim;
        invalid = 1'b1;
      end else begin
        result = mid.mag;
      end
    end else begin
      if (mid.neg) begin
        invalid = mid.huge || (mid.mag != '0);
      end else if (mid.huge || mid.mag > u_lim) begin
        result  = u_lim;
        invalid = 1'b1;
      end else begin
        result = mid.mag;
      end
    end
    inexact = mid.lost && !invalid;
  end
endmodule

// File: rtl/fp_to_fixed_conv.sv
module fp_to_fixed_conv
  import fxc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FP_W-1:0]   in_value,
  input  logic              in_signed,
  input  logic              in_half,
  input  logic [FRAC_W-1:0] in_frac_bits,
  input  logic              in_flush,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_result,
  output logic              out_invalid,
  output logic              out_inexact,
  output logic              out_denorm
);
  fxc_mid_t         mid_d, mid_q;
  logic             mid_vld_q;
  logic [OUT_W-1:0] res_d;
  logic             inv_d, inx_d;

  fxc_decode u_decode (
    .value     (in_value),
    .is_signed (in_signed),
    .half      (in_half),
    .frac      (in_frac_bits),
    .flush     (in_flush),
    .mid       (mid_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mid_q     <= '0;
      mid_vld_q <= 1'b0;
    end else begin
      mid_vld_q <= in_valid;
      mid_q     <= in_valid ? mid_d : '0;
    end
  end

  fxc_clamp u_clamp (
    .mid     (mid_q),
    .result  (res_d),
    .invalid (inv_d),
    .inexact (inx_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_denorm  <= 1'b0;
    end else begin
      out_valid   <= mid_vld_q;
      out_result  <= mid_vld_q ? res_d : '0;
      out_invalid <= mid_vld_q && inv_d;
      out_inexact <= mid_vld_q && inx_d;
      out_denorm  <= mid_vld_q && mid_q.denorm;
    end
  end

  // R9: two-cycle latency
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> ##2 out_valid);
  // R10: outputs quiet without valid
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_result == '0 && !out_invalid && !out_inexact && !out_denorm));
  // R6: saturation never reports inexact
  a_r6_inv_no_inexact: assert property (@(posedge clk) disable iff (!rst_n)
    out_invalid |-> !out_inexact);
  // R4: flushed operand yields a clean zero
  a_r4_denorm_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_denorm |-> (out_result == '0 && !out_invalid && !out_inexact));
  // R8: half-width results are extended into the upper half
  a_r8_half_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mid_q.half)) |->
      (out_result[OUT_W-1:HALF_W] ==
       {(OUT_W-HALF_W){$past(mid_q.is_signed) & out_result[HALF_W-1]}}));
endmodule

// File: tb/fp_to_fixed_conv_bench.sv
module fp_to_fixed_conv_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_value = '0;
  logic        in_signed = 1'b0, in_half = 1'b0, in_flush = 1'b0;
  logic [4:0]  in_frac_bits = '0;
  logic        out_valid, out_invalid, out_inexact, out_denorm;
  logic [31:0] out_result;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct packed {
    logic [31:0] res;
    logic        inv;
    logic        inx;
    logic        den;
    logic [31:0] at;
    logic [3:0]  tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_to_fixed_conv u_fp_to_fixed_conv (
    .clk, .rst_n, .in_valid, .in_value, .in_signed, .in_half,
    .in_frac_bits, .in_flush, .out_valid, .out_result,
    .out_invalid, .out_inexact, .out_denorm
  );

  function automatic exp_t model(logic [31:0] b, logic sg, logic hf,
                                 logic [4:0] f, logic fl);
    exp_t r;
    int   ex;
    real  v, s, t, lo, hi;
    r = '0;
    ex = int'(b[30:23]);
    r.tag = 4'd2;
    if (ex == 255 && b[22:0] != 0) begin
      r.inv = 1'b1; r.tag = 4'd5; return r;
    end
    if (ex == 0 && b[22:0] != 0 && fl) begin
      r.den = 1'b1; r.tag = 4'd4; return r;
    end
    if (ex == 255)      v = 1.0e40;
    else if (ex == 0)   v = (real'(b[22:0]) / 8388608.0) * (2.0 ** (-126));
    else                v = (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** (ex - 127));
    if (b[31]) v = -v;
    if (ex == 0 && b[22:0] != 0) r.tag = 4'd4;
    s = v * (2.0 ** f);
    t = (s >= 0.0) ? $floor(s) : $ceil(s);
    if (sg) begin
      lo = hf ? -32768.0 : -2147483648.0;
      hi = hf ? 32767.0 : 2147483647.0;
    end else begin
      lo = 0.0;
      hi = hf ? 65535.0 : 4294967295.0;
    end
    if (t < lo) begin
      r.res = 32'(longint'(lo)); r.inv = 1'b1; r.tag = sg ? 4'd6 : 4'd7;
    end else if (t > hi) begin
      r.res = 32'(longint'(hi)); r.inv = 1'b1; r.tag = sg ? 4'd6 : 4'd7;
    end else begin
      r.res = 32'(longint'(t));
      r.inx = (t != s);
      if (r.inx && r.tag == 4'd2) r.tag = 4'd3;
      if (hf) r.tag = 4'd8;
    end
    return r;
  endfunction

  task automatic check_out();
    exp_t e;
    if (out_valid) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R9: out_valid with nothing pending at cycle %0d (act 1 exp 0)", cyc);
      end else begin
        e = q.pop_front();
        if (cyc != int'(e.at) + 2) begin
          errors++;
          $display("FAIL R9: result at cycle %0d, expected cycle %0d", cyc, e.at + 2);
        end
        checks++;
        if ({out_result, out_invalid, out_inexact, out_denorm} !== {e.res, e.inv, e.inx, e.den}) begin
          errors++;
          $display("FAIL R%0d: act res=%h inv=%b inx=%b den=%b exp res=%h inv=%b inx=%b den=%b",
                   e.tag, out_result, out_invalid, out_inexact, out_denorm,
                   e.res, e.inv, e.inx, e.den);
        end
      end
    end else begin
      checks++;
      // R10 quiet outputs; R9 nothing overdue
      if ({out_result, out_invalid, out_inexact, out_denorm} !== '0 ||
          (q.size() != 0 && cyc >= int'(q[0].at) + 2)) begin
        errors++;
        $display("FAIL R10/R9: idle act res=%h inv=%b inx=%b den=%b exp all zero, valid on time",
                 out_result, out_invalid, out_inexact, out_denorm);
      end
    end
  endtask

  task automatic step(logic v, logic [31:0] b, logic sg, logic hf,
                      logic [4:0] f, logic fl);
    @(negedge clk);
    cyc++;
    check_out();
    in_valid = v; in_value = b; in_signed = sg; in_half = hf;
    in_frac_bits = f; in_flush = fl;
    if (v) begin
      exp_t e;
      e = model(b, sg, hf, f, fl);
      e.at = 32'(cyc);
      q.push_back(e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish (act hung, exp done)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    checks++;
    if ({out_valid, out_result, out_invalid, out_inexact, out_denorm} !== '0) begin
      errors++;
      $display("FAIL R1: reset outputs act %b exp 0", out_valid);
    end
    rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0);
    checks++;
    if (out_valid !== 1'b0) begin
      errors++; $display("FAIL R1: out_valid after reset act 1 exp 0");
    end
    // directed corners
    step(1, 32'h3FC00000, 1, 0, 0, 0); // R3 1.5 -> 1 inexact
    step(1, 32'hBFC00000, 1, 0, 0, 0); // R2 -1.5 -> -1
    step(1, 32'h4F000000, 1, 0, 0, 0); // R6 2^31 saturate
    step(1, 32'hCF000000, 1, 0, 0, 0); // R6 -2^31 exact
    step(1, 32'h7F800000, 1, 0, 3, 0); // R6 +inf
    step(1, 32'hFF800000, 1, 1, 3, 0); // R6 -inf half
    step(1, 32'h7FC00000, 1, 0, 0, 0); // R5 NaN
    step(1, 32'h00000001, 1, 0, 31, 1); // R4 flushed
    step(1, 32'h80400000, 0, 0, 31, 0); // R4 not flushed
    step(1, 32'h471C4000, 1, 1, 0, 0); // R8 40000 half signed sat
    step(1, 32'hC7000000, 1, 1, 0, 0); // R8 -32768 exact
    step(1, 32'hBFC00000, 0, 0, 0, 0); // R7 -1.5 unsigned
    step(1, 32'hBF000000, 0, 0, 0, 0); // R7 -0.5 unsigned
    step(1, 32'h477FFF80, 0, 1, 0, 0); // R8 65535.5 unsigned half
    step(1, 32'h477FFF80, 0, 1, 1, 0); // R7 saturate half
    step(1, 32'h3F800000, 0, 0, 31, 0); // R2 2^31 unsigned
    step(1, 32'h3F800000, 1, 0, 31, 0); // R6 signed sat
    step(0, 0, 0, 0, 0, 0);
    // random mix, valid gaps
    for (int i = 0; i < 600; i++) begin
      logic [31:0] b;
      b = $urandom();
      if ($urandom_range(3) != 0) b[30:23] = 8'(100 + $urandom_range(59));
      if ($urandom_range(15) == 0) b[30:23] = 8'd0;
      step($urandom_range(3) != 0, b, 1'($urandom()), 1'($urandom()),
           5'($urandom()), 1'($urandom()));
    end
    repeat (4) step(0, 0, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule